// File: doc/BRIEF.md
# Tag-Only Cache Access-Time Model

This block models the timing of one cache level without holding any data. It keeps only valid bits, tags and a per-set recency order. For every access it returns the number of cycles the access cost. A requester presents a 32-bit address. When the line is resident, the block answers with its configured hit time. When the line is absent, the block forwards the address to a next-level port and waits for that level to answer with its own access time. It then installs the line into the least recently used way and answers with the hit time plus the next-level time.

Several instances can be chained into a hierarchy, because the response port of one level feeds the next-level port of the level below. An outer level can drop a line from this level through the invalidation port, for example when an inclusive lower level evicts that line. Three running counters record references, misses and accumulated penalty cycles. With zero sets the block keeps no state and wires requests and responses straight through.

Top module: `tag_cache_timer`

## Requirements
- R1: Every accepted request (`req_valid_i` high while `req_ready_o` is high) increments `refs_o` by one at that clock edge. Nothing else changes it.
- R2: An accepted request that misses increments `misses_o` by one at the acceptance edge. Hits and idle cycles leave it unchanged.
- R3: On a hit, `rsp_valid_o` pulses for one cycle right after the acceptance edge, with `rsp_cycles_o` equal to HIT_CYCLES. `penalty_o` is unchanged.
- R4: On a miss, `nl_req_valid_o` rises after the acceptance edge and carries the unchanged request address on `nl_req_addr_o`. It stays high until a cycle with `nl_rsp_valid_i` high. In the following cycle `rsp_valid_o` pulses with `rsp_cycles_o` = HIT_CYCLES + `nl_rsp_cycles_i`, and `penalty_o` has grown by `nl_rsp_cycles_i`.
- R5: The set index is (address >> log2(LINE_BYTES)) mod SETS, and the tag is the bits above the index. Two addresses in the same line share a hit. Two different tags in one set are distinct lines.
- R6: A fill replaces the least recently used way of its set. A hit or a fill makes the accessed way most recently used, and every way that was more recent than it ages by one. After reset, way 0 is most recent and way WAYS-1 is least recent.
- R7: An invalidation (`inv_valid_i` with `inv_addr_i`) clears the valid bit of any way in the indexed set whose tag matches. It changes neither the recency order nor any counter. An address that is not resident is unaffected.
- R8: While a miss is outstanding, `req_ready_o` is low and no new request is taken. At most one next-level request exists at a time.
- R9: With SETS = 0 the block is a pass-through. `req_ready_o` is 1, the next-level request valid and address follow the request inputs, the response follows the next-level response, and all three counters stay zero.
- R10: After reset all lines are invalid, the counters are zero, `req_ready_o` is high, and no request or response is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request |
| req_addr_i | input | 32 | Byte address of the access |
| req_ready_o | output | 1 | Block can take a request this cycle |
| rsp_valid_o | output | 1 | One-cycle pulse carrying the access cost |
| rsp_cycles_o | output | CNT_W | Cycles consumed by the access |
| nl_req_valid_o | output | 1 | Request to the next level, held until answered |
| nl_req_addr_o | output | 32 | Address sent to the next level |
| nl_rsp_valid_i | input | 1 | Next level answers |
| nl_rsp_cycles_i | input | CNT_W | Access time reported by the next level |
| inv_valid_i | input | 1 | Invalidate request |
| inv_addr_i | input | 32 | Byte address of the line to invalidate |
| refs_o | output | CNT_W | Reference count |
| misses_o | output | CNT_W | Miss count |
| penalty_o | output | CNT_W | Sum of next-level access times |

## Verification
The main sequence works on a two-way configuration. It first fills one set with two tags, then touches the older tag, so that a third tag in that set must evict the untouched one and not the touched one. That shows true recency from a simple fill order. Same-line offsets and an address in another set separate index and tag extraction from a plain address compare. The bench varies next-level latencies, including zero, and checks that each latency lands in both the response and the penalty. Invalidations of a resident line and of an absent line show that only the matching line is dropped and that no counter moves. A second instance with zero sets is driven directly, to show that it passes requests and responses through without keeping any count.

// File: rtl/tcl_pkg.sv
package tcl_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } tcl_state_e;

  // width of a field addressing n items, never below one bit
  function automatic int unsigned sel_bits(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tcl_tag_store.sv
module tcl_tag_store #(
  parameter int unsigned SETS  = 4,
  parameter int unsigned WAYS  = 2,
  parameter int unsigned TAG_W = 26,
  parameter int unsigned IDX_W = 2,
  parameter int unsigned WAY_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             lk_hit_o,
  output logic [WAY_W-1:0] lk_way_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic             inv_en_i,
  input  logic [IDX_W-1:0] inv_idx_i,
  input  logic [TAG_W-1:0] inv_tag_i
);

  logic             valid_q [SETS][WAYS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[lk_idx_i][w] && (tag_q[lk_idx_i][w] == lk_tag_i);
  end

  assign lk_hit_o = |hit_vec;

  always_comb begin
    lk_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) lk_way_o = WAY_W'(w);
    end
  end

  // a fill in the same cycle as a matching invalidation wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          valid_q[s][w] <= 1'b0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          if (inv_en_i && (IDX_W'(s) == inv_idx_i) && (tag_q[s][w] == inv_tag_i))
            valid_q[s][w] <= 1'b0;
          if (wr_en_i && (IDX_W'(s) == wr_idx_i) && (WAY_W'(w) == wr_way_i))
            valid_q[s][w] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[wr_idx_i][wr_way_i] <= wr_tag_i;
  end

endmodule

// File: rtl/tcl_lru.sv
module tcl_lru #(
  parameter int unsigned SETS  = 4,
  parameter int unsigned WAYS  = 2,
  parameter int unsigned IDX_W = 2,
  parameter int unsigned WAY_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [IDX_W-1:0] vic_idx_i,
  output logic [WAY_W-1:0] vic_way_o
);

  // rank 0 = most recent, WAYS-1 = victim
  logic [WAY_W-1:0] rank_q [SETS][WAYS];
  logic [WAY_W-1:0] old_rank;

  assign old_rank = rank_q[touch_idx_i][touch_way_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          rank_q[s][w] <= WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          rank_q[touch_idx_i][w] <= '0;
        else if (rank_q[touch_idx_i][w] < old_rank)
          rank_q[touch_idx_i][w] <= rank_q[touch_idx_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    vic_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (rank_q[vic_idx_i][w] == WAY_W'(WAYS - 1)) vic_way_o = WAY_W'(w);
    end
  end

endmodule

// File: rtl/tcl_stats.sv
module tcl_stats #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_inc_i,
  input  logic             miss_inc_i,
  input  logic             pen_add_i,
  input  logic [CNT_W-1:0] pen_val_i,
  output logic [CNT_W-1:0] refs_o,
  output logic [CNT_W-1:0] misses_o,
  output logic [CNT_W-1:0] penalty_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      refs_o    <= '0;
      misses_o  <= '0;
      penalty_o <= '0;
    end else begin
      if (ref_inc_i)  refs_o    <= refs_o + 1'b1;
      if (miss_inc_i) misses_o  <= misses_o + 1'b1;
      if (pen_add_i)  penalty_o <= penalty_o + pen_val_i;
    end
  end

endmodule

// File: rtl/tag_cache_timer.sv
module tag_cache_timer
  import tcl_pkg::*;
#(
  parameter int unsigned SETS       = 4,
  parameter int unsigned WAYS       = 2,
  parameter int unsigned HIT_CYCLES = 2,
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned CNT_W      = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [31:0]      req_addr_i,
  output logic             req_ready_o,
  output logic             rsp_valid_o,
  output logic [CNT_W-1:0] rsp_cycles_o,
  output logic             nl_req_valid_o,
  output logic [31:0]      nl_req_addr_o,
  input  logic             nl_rsp_valid_i,
  input  logic [CNT_W-1:0] nl_rsp_cycles_i,
  input  logic             inv_valid_i,
  input  logic [31:0]      inv_addr_i,
  output logic [CNT_W-1:0] refs_o,
  output logic [CNT_W-1:0] misses_o,
  output logic [CNT_W-1:0] penalty_o
);

  // SETS and LINE_BYTES are powers of two, LINE_BYTES >= 2
  localparam int unsigned OFF_W    = $clog2(LINE_BYTES);
  localparam int unsigned IDX_BITS = (SETS > 1) ? $clog2(SETS) : 0;
  localparam int unsigned IDX_W    = sel_bits(SETS);
  localparam int unsigned WAY_W    = sel_bits(WAYS);
  localparam int unsigned TAG_W    = 32 - OFF_W - IDX_BITS;
  localparam logic [CNT_W-1:0] HIT_C = CNT_W'(HIT_CYCLES);

  if (SETS == 0) begin : g_bypass
    logic unused_byp;
    assign unused_byp     = ^{clk_i, rst_ni, inv_valid_i, inv_addr_i};
    assign req_ready_o    = 1'b1;
    assign nl_req_valid_o = req_valid_i;
    assign nl_req_addr_o  = req_addr_i;
    assign rsp_valid_o    = nl_rsp_valid_i;
    assign rsp_cycles_o   = nl_rsp_cycles_i;
    assign refs_o         = '0;
    assign misses_o       = '0;
    assign penalty_o      = '0;
  end else begin : g_cache
    tcl_state_e       state_q;
    logic [31:0]      pend_addr_q;
    logic             rsp_valid_q;
    logic [CNT_W-1:0] rsp_cycles_q;

    logic [31:0]      req_line, pend_line, inv_line;
    logic [IDX_W-1:0] lk_idx, pend_idx, inv_idx;
    logic [TAG_W-1:0] lk_tag, pend_tag, inv_tag;
    logic             lk_hit;
    logic [WAY_W-1:0] lk_way, vic_way;
    logic             accept, fill, touch;
    logic [IDX_W-1:0] touch_idx;
    logic [WAY_W-1:0] touch_way;
    logic             unused_lo;

    assign unused_lo = ^{req_addr_i[OFF_W-1:0], inv_addr_i[OFF_W-1:0]};

    assign req_line  = req_addr_i  >> OFF_W;
    assign pend_line = pend_addr_q >> OFF_W;
    assign inv_line  = inv_addr_i  >> OFF_W;
    assign lk_idx    = IDX_W'(req_line  % SETS);
    assign pend_idx  = IDX_W'(pend_line % SETS);
    assign inv_idx   = IDX_W'(inv_line  % SETS);
    assign lk_tag    = TAG_W'(req_line  >> IDX_BITS);
    assign pend_tag  = TAG_W'(pend_line >> IDX_BITS);
    assign inv_tag   = TAG_W'(inv_line  >> IDX_BITS);

    assign accept    = req_valid_i && (state_q == ST_IDLE);
    assign fill      = (state_q == ST_WAIT) && nl_rsp_valid_i;
    assign touch     = (accept && lk_hit) || fill;
    assign touch_idx = fill ? pend_idx : lk_idx;
    assign touch_way = fill ? vic_way  : lk_way;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        state_q      <= ST_IDLE;
        pend_addr_q  <= '0;
        rsp_valid_q  <= 1'b0;
        rsp_cycles_q <= '0;
      end else begin
        rsp_valid_q <= touch;
        if (fill) begin
          state_q      <= ST_IDLE;
          rsp_cycles_q <= HIT_C + nl_rsp_cycles_i;
        end else if (accept) begin
          rsp_cycles_q <= HIT_C;
          if (!lk_hit) begin
            state_q     <= ST_WAIT;
            pend_addr_q <= req_addr_i;
          end
        end
      end
    end

    tcl_tag_store #(
      .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
    ) u_tags (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lk_idx_i  (lk_idx),
      .lk_tag_i  (lk_tag),
      .lk_hit_o  (lk_hit),
      .lk_way_o  (lk_way),
      .wr_en_i   (fill),
      .wr_idx_i  (pend_idx),
      .wr_way_i  (vic_way),
      .wr_tag_i  (pend_tag),
      .inv_en_i  (inv_valid_i),
      .inv_idx_i (inv_idx),
      .inv_tag_i (inv_tag)
    );

    tcl_lru #(
      .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)
    ) u_lru (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .touch_i     (touch),
      .touch_idx_i (touch_idx),
      .touch_way_i (touch_way),
      .vic_idx_i   (pend_idx),
      .vic_way_o   (vic_way)
    );

    tcl_stats #(.CNT_W(CNT_W)) u_stats (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ref_inc_i  (accept),
      .miss_inc_i (accept && !lk_hit),
      .pen_add_i  (fill),
      .pen_val_i  (nl_rsp_cycles_i),
      .refs_o     (refs_o),
      .misses_o   (misses_o),
      .penalty_o  (penalty_o)
    );

    assign req_ready_o    = (state_q == ST_IDLE);
    assign nl_req_valid_o = (state_q == ST_WAIT);
    assign nl_req_addr_o  = pend_addr_q;
    assign rsp_valid_o    = rsp_valid_q;
    assign rsp_cycles_o   = rsp_cycles_q;
  end

endmodule

// File: rtl/tcl_checker.sv
module tcl_checker #(
  parameter int unsigned SETS       = 4,
  parameter int unsigned HIT_CYCLES = 2,
  parameter int unsigned CNT_W      = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             rsp_valid_o,
  input logic [CNT_W-1:0] rsp_cycles_o,
  input logic             nl_req_valid_o,
  input logic             nl_rsp_valid_i,
  input logic [CNT_W-1:0] nl_rsp_cycles_i,
  input logic             inv_valid_i,
  input logic [CNT_W-1:0] refs_o,
  input logic [CNT_W-1:0] misses_o,
  input logic [CNT_W-1:0] penalty_o
);

  localparam logic [CNT_W-1:0] HIT_C = CNT_W'(HIT_CYCLES);

  if (SETS != 0) begin : g_cache_chk
    a_r1_ref_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_ready_o) |=> (refs_o == $past(refs_o) + 1'b1));

    a_r2_miss_only_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(req_valid_i && req_ready_o) |=> $stable(misses_o));

    a_r3_hit_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(req_valid_i && req_ready_o) && (misses_o == $past(misses_o)))
      |-> (rsp_valid_o && (rsp_cycles_o == HIT_C) && $stable(penalty_o)));

    a_r4_miss_cost: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (nl_req_valid_o && nl_rsp_valid_i) |=>
      (rsp_valid_o && (rsp_cycles_o == HIT_C + $past(nl_rsp_cycles_i))
       && (penalty_o == $past(penalty_o) + $past(nl_rsp_cycles_i))));

    a_r7_inv_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inv_valid_i && !(req_valid_i && req_ready_o) && !(nl_req_valid_o && nl_rsp_valid_i))
      |=> ($stable(refs_o) && $stable(misses_o) && $stable(penalty_o)));

    a_r8_single_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nl_req_valid_o |-> !req_ready_o);
  end else begin : g_bypass_chk
    a_r9_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsp_valid_o == nl_rsp_valid_i) && (rsp_cycles_o == nl_rsp_cycles_i)
      && (nl_req_valid_o == req_valid_i) && req_ready_o);

    a_r9_no_stats: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (refs_o == '0) && (misses_o == '0) && (penalty_o == '0) && (inv_valid_i || !inv_valid_i));
  end

endmodule

bind tag_cache_timer tcl_checker #(
  .SETS(SETS), .HIT_CYCLES(HIT_CYCLES), .CNT_W(CNT_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_cycles_o    (rsp_cycles_o),
  .nl_req_valid_o  (nl_req_valid_o),
  .nl_rsp_valid_i  (nl_rsp_valid_i),
  .nl_rsp_cycles_i (nl_rsp_cycles_i),
  .inv_valid_i     (inv_valid_i),
  .refs_o          (refs_o),
  .misses_o        (misses_o),
  .penalty_o       (penalty_o)
);

// File: tb/tag_cache_timer_test.sv
module tag_cache_timer_test;

  localparam int SETS = 4;
  localparam int WAYS = 2;
  localparam int HIT  = 2;
  localparam int LINE = 16;
  localparam int OFF  = 4;
  localparam int CW   = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst_n = 1'b0;

  logic          req_v = 0, nl_rsp_v = 0, inv_v = 0;
  logic [31:0]   req_addr = 0, inv_addr = 0;
  logic [CW-1:0] nl_cyc = 0;
  logic          ready, rsp_v, nl_req_v;
  logic [CW-1:0] rsp_cyc, refs, misses, pen;
  logic [31:0]   nl_addr;

  tag_cache_timer #(.SETS(SETS), .WAYS(WAYS), .HIT_CYCLES(HIT), .LINE_BYTES(LINE), .CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_v), .req_addr_i(req_addr),
    .req_ready_o(ready), .rsp_valid_o(rsp_v), .rsp_cycles_o(rsp_cyc),
    .nl_req_valid_o(nl_req_v), .nl_req_addr_o(nl_addr), .nl_rsp_valid_i(nl_rsp_v),
    .nl_rsp_cycles_i(nl_cyc), .inv_valid_i(inv_v), .inv_addr_i(inv_addr),
    .refs_o(refs), .misses_o(misses), .penalty_o(pen));

  logic          b_req_v = 0, b_nl_rsp_v = 0;
  logic [31:0]   b_req_addr = 0;
  logic [CW-1:0] b_nl_cyc = 0;
  logic          b_ready, b_rsp_v, b_nl_req_v;
  logic [CW-1:0] b_rsp_cyc, b_refs, b_misses, b_pen;
  logic [31:0]   b_nl_addr;

  tag_cache_timer #(.SETS(0), .WAYS(WAYS), .HIT_CYCLES(HIT), .LINE_BYTES(LINE), .CNT_W(CW)) uut_byp (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(b_req_v), .req_addr_i(b_req_addr),
    .req_ready_o(b_ready), .rsp_valid_o(b_rsp_v), .rsp_cycles_o(b_rsp_cyc),
    .nl_req_valid_o(b_nl_req_v), .nl_req_addr_o(b_nl_addr), .nl_rsp_valid_i(b_nl_rsp_v),
    .nl_rsp_cycles_i(b_nl_cyc), .inv_valid_i(1'b0), .inv_addr_i(32'h0),
    .refs_o(b_refs), .misses_o(b_misses), .penalty_o(b_pen));

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // behavioural reference model
  bit          mv [SETS][WAYS];
  int unsigned mt [SETS][WAYS];
  int          ord[SETS][$];
  bit          m_busy;
  logic [31:0] m_addr;
  int          e_refs, e_miss, e_pen, e_rc;
  bit          e_rv;

  function automatic void touch(int s, int w);
    for (int i = 0; i < ord[s].size(); i++) begin
      if (ord[s][i] == w) begin
        ord[s].delete(i);
        break;
      end
    end
    ord[s].push_front(w);
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    bit fill;
    int s, hitw, vw;
    int unsigned ln;
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) begin
        ord[i] = {};
        for (int w = 0; w < WAYS; w++) begin
          ord[i].push_back(w);
          mv[i][w] = 0;
        end
      end
      m_busy = 0; m_addr = 0;
      e_refs = 0; e_miss = 0; e_pen = 0; e_rv = 0; e_rc = 0;
    end else begin
      fill = m_busy && nl_rsp_v;
      e_rv = 0;
      if (!m_busy && req_v) begin
        ln = req_addr >> OFF;
        s = ln % SETS;
        hitw = -1;
        for (int w = 0; w < WAYS; w++)
          if (mv[s][w] && mt[s][w] == ln / SETS) hitw = w;
        e_refs++;
        if (hitw >= 0) begin
          e_rv = 1; e_rc = HIT;
          touch(s, hitw);
        end else begin
          e_miss++;
          m_busy = 1;
          m_addr = req_addr;
        end
      end
      if (inv_v) begin
        ln = inv_addr >> OFF;
        s = ln % SETS;
        for (int w = 0; w < WAYS; w++)
          if (mt[s][w] == ln / SETS) mv[s][w] = 0;
      end
      if (fill) begin
        ln = m_addr >> OFF;
        s = ln % SETS;
        vw = ord[s][$];
        mv[s][vw] = 1;
        mt[s][vw] = ln / SETS;
        touch(s, vw);
        e_pen += int'(nl_cyc);
        e_rv = 1;
        e_rc = HIT + int'(nl_cyc);
        m_busy = 0;
      end
    end
  end

  bit running = 0;
  always @(negedge clk) begin
    if (rst_n && running) begin
      chk("R1 refs", refs, e_refs);
      chk("R2 misses", misses, e_miss);
      chk("R4 penalty", pen, e_pen);
      chk("R8 ready", {31'b0, ready}, {31'b0, !m_busy});
      chk("R4 nl_req_valid", {31'b0, nl_req_v}, {31'b0, m_busy});
      if (m_busy) chk("R4 nl_req_addr", nl_addr, m_addr);
      chk("R3 rsp_valid", {31'b0, rsp_v}, {31'b0, e_rv});
      if (e_rv) chk("R3/R4 rsp_cycles", rsp_cyc, e_rc);
    end
  end

  // exp_miss: 1 if the scenario requires a miss, 0 for a hit
  task automatic access(string tag, logic [31:0] addr, int lat, bit exp_miss);
    logic [31:0] m0;
    @(negedge clk); #1;
    m0 = misses;
    req_v = 1; req_addr = addr;
    @(negedge clk); #1;
    req_v = 0;
    chk(tag, misses - m0, {31'b0, exp_miss});
    if (m_busy) begin
      for (int i = 0; i < lat; i++) begin
        @(negedge clk); #1;
      end
      nl_rsp_v = 1; nl_cyc = lat;
      @(negedge clk); #1;
      nl_rsp_v = 0;
    end
    @(negedge clk);
  endtask

  task automatic inval(logic [31:0] addr);
    logic [31:0] r0, m0, p0;
    @(negedge clk); #1;
    r0 = refs; m0 = misses; p0 = pen;
    inv_v = 1; inv_addr = addr;
    @(negedge clk); #1;
    inv_v = 0;
    chk("R7 refs after invalidate", refs, r0);
    chk("R7 misses after invalidate", misses, m0);
    chk("R7 penalty after invalidate", pen, p0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 ready in reset", {31'b0, ready}, 32'd1);
    chk("R10 rsp_valid in reset", {31'b0, rsp_v}, 32'd0);
    chk("R10 nl_req_valid in reset", {31'b0, nl_req_v}, 32'd0);
    chk("R10 refs in reset", refs, 32'd0);
    chk("R10 penalty in reset", pen, 32'd0);
    #1 rst_n = 1;
    running = 1;

    access("R10 cold miss 0x100", 32'h100, 5, 1);
    access("R5 same line 0x104 hits", 32'h104, 0, 0);
    access("R5 other tag 0x140 misses", 32'h140, 3, 1);
    access("R6 touch 0x100", 32'h100, 0, 0);
    access("R6 0x180 misses", 32'h180, 2, 1);
    access("R6 touched 0x100 kept", 32'h100, 0, 0);
    access("R6 LRU 0x140 evicted", 32'h140, 0, 1);
    access("R5 set1 0x110 misses", 32'h110, 4, 1);
    access("R5 set1 0x11c hits", 32'h11c, 0, 0);
    inval(32'h100);
    access("R7 invalidated 0x100 misses", 32'h100, 1, 1);
    inval(32'h900);
    access("R7 absent invalidate leaves 0x110", 32'h110, 0, 0);
    access("R7 0x100 refilled hits", 32'h100, 0, 0);
    access("R5 0x500 shares set0, new tag", 32'h500, 6, 1);
    access("R6 0x140 evicted by 0x500", 32'h140, 7, 1);

    // R9 pass-through instance
    @(negedge clk); #1;
    b_req_v = 1; b_req_addr = 32'h1234_5678;
    #1;
    chk("R9 bypass ready", {31'b0, b_ready}, 32'd1);
    chk("R9 bypass nl_req_valid", {31'b0, b_nl_req_v}, 32'd1);
    chk("R9 bypass nl_req_addr", b_nl_addr, 32'h1234_5678);
    b_nl_rsp_v = 1; b_nl_cyc = 37;
    #1;
    chk("R9 bypass rsp_valid", {31'b0, b_rsp_v}, 32'd1);
    chk("R9 bypass rsp_cycles", b_rsp_cyc, 32'd37);
    @(negedge clk); #1;
    b_req_v = 0; b_nl_rsp_v = 0;
    @(negedge clk);
    chk("R9 bypass refs", b_refs, 32'd0);
    chk("R9 bypass misses", b_misses, 32'd0);
    chk("R9 bypass penalty", b_pen, 32'd0);
    chk("R9 bypass rsp idle", {31'b0, b_rsp_v}, 32'd0);

    repeat (2) @(negedge clk);
    running = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule